// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Clear-on-Compare

This block is a byte-organised up-counter for interval timing and event counting. It advances only on cycles where an external prescaler raises a count-enable strobe, so one system clock can drive several timers at different rates. A two-bit mode input selects one of three ways of counting. The first wraps the low byte freely. The second clears the low byte when it reaches a programmable top value. The third chains the low and high bytes into one wide counter.

Software loads either counter byte and the compare byte through write strobes. Two sticky flags report events: an overflow flag raised when the counter rolls over to zero, and a compare flag raised when the low byte sits on the compare value at an enabled count. Each flag stays high until its own acknowledge input clears it. The compare byte is not double buffered, so a new top value takes effect at once. If the new top is below the current count, the counter climbs past it to the all-ones value and wraps before a match can happen.

Top module: `mtc_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the count is zero and both flags are low. The compare byte also resets to zero.
- R2: The counter changes only on an edge where `tick` is high or a counter write strobe is high. In every other cycle it holds its value.
- R3: Mode encodings are 0 for free 8-bit, 1 for clear-on-compare and 2 for free 16-bit; encoding 3 acts like 0. In free 8-bit mode each tick adds one to the low byte, wraps 0xFF to 0x00, and leaves the high byte unchanged.
- R4: `ovf_flag` rises on the same edge at which the counter becomes zero after its maximum. In the 8-bit modes the low byte is the counter; in 16-bit mode both bytes together are the counter.
- R5: In clear-on-compare mode, a tick that finds the low byte equal to the compare byte loads zero into the low byte. The period is therefore compare+1 ticks.
- R6: In every mode, a tick that finds the low byte equal to the compare byte raises `cmp_flag` on that edge. In 16-bit mode a match never clears the counter.
- R7: A compare write takes effect on the next cycle. In clear-on-compare mode, if the new value is below the count, the low byte runs on to 0xFF, wraps to 0x00 (raising `ovf_flag`), and then matches when it reaches the new value.
- R8: In 16-bit mode a tick adds one to the combined {high, low} value, carrying from low to high, and 0xFFFF wraps to 0x0000.
- R9: A counter byte write wins over a simultaneous tick. The written byte is loaded, neither byte increments, and no flag is raised by that cycle.
- R10: A flag stays high until its acknowledge input is seen. When a set event and an acknowledge happen on the same edge, the flag ends high.
- R11: In the free modes, a counter write is accepted at any count value and counting resumes from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| mode | input | 2 | Counting mode select |
| cnt_lo_we | input | 1 | Write strobe for the low counter byte |
| cnt_hi_we | input | 1 | Write strobe for the high counter byte |
| cnt_wdata | input | BYTE_W | Data for counter byte writes |
| cmp_we | input | 1 | Write strobe for the compare byte |
| cmp_wdata | input | BYTE_W | Data for the compare byte |
| ovf_ack | input | 1 | Clears the overflow flag |
| cmp_ack | input | 1 | Clears the compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| count | output | 2*BYTE_W | Current {high, low} count |

## Verification
The counter is run under each mode with gapped and back-to-back ticks. This separates a counter that gates on the strobe from one that runs on every clock, and shows whether the high byte is isolated in the 8-bit modes and carried into in 16-bit mode. In clear-on-compare mode, a short top value shows whether the clear happens on the matching tick. A compare value lowered below the running count shows whether the match is missed and the counter instead wraps through 0xFF. Writes on the same edge as a tick, and acknowledges on the same edge as a flag event, expose which side wins in each race.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_FREE8  = 2'd0,
    TM_CLRCMP = 2'd1,
    TM_FREE16 = 2'd2,
    TM_RSVD   = 2'd3
  } tm_mode_e;

endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic ack,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (ack)     flag <= 1'b0;
  end

  // R10: an event beats a same-cycle acknowledge
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);

  // R10: without an acknowledge the flag stays high
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag && !ack) |=> flag);

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] lo_val,
  output logic [BYTE_W-1:0] top_val,
  output logic              hit
);

  logic [BYTE_W-1:0] top_q;

  // Loaded directly: no shadow copy, so a new top takes effect at once
  always_ff @(posedge clk) begin
    if (rst)     top_q <= '0;
    else if (we) top_q <= wdata;
  end

  assign top_val = top_q;
  assign hit     = (lo_val == top_q);

  // R7: a compare write is visible on the next cycle
  p_cmp_load_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> (top_val == $past(wdata)));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  tm_mode_e            mode,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                hit,
  output logic [BYTE_W-1:0]   lo_q,
  output logic [BYTE_W-1:0]   hi_q,
  output logic                ovf_evt,
  output logic                cmp_evt
);

  localparam logic [BYTE_W-1:0] LO_MAX = '1;

  logic [BYTE_W-1:0] lo_d, hi_d;
  logic              adv;

  assign adv = tick && !(lo_we || hi_we);

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    ovf_evt = 1'b0;
    cmp_evt = 1'b0;
    if (lo_we) lo_d = wdata;
    if (hi_we) hi_d = wdata;
    if (adv) begin
      cmp_evt = hit;
      case (mode)
        TM_CLRCMP: begin
          lo_d    = hit ? '0 : lo_q + 1'b1;
          ovf_evt = (lo_q == LO_MAX);
        end
        TM_FREE16: begin
          {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
          ovf_evt      = &{hi_q, lo_q};
        end
        default: begin
          lo_d    = lo_q + 1'b1;
          ovf_evt = (lo_q == LO_MAX);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R2: no tick and no write means the count holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !lo_we && !hi_we) |=> ($stable(lo_q) && $stable(hi_q)));

  // R9: a low-byte write loads the data even when a tick arrives with it
  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (lo_q == $past(wdata)));

  // R8: wide mode adds one across both bytes
  p_wide_inc_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == TM_FREE16) |=> ({hi_q, lo_q} == $past({hi_q, lo_q}) + 1'b1));

endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              cnt_lo_we,
  input  logic              cnt_hi_we,
  input  logic [BYTE_W-1:0] cnt_wdata,
  input  logic              cmp_we,
  input  logic [BYTE_W-1:0] cmp_wdata,
  input  logic              ovf_ack,
  input  logic              cmp_ack,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic [CNT_W-1:0]  count
);

  tm_mode_e          mode_e;
  logic [BYTE_W-1:0] lo_q, hi_q, top_val;
  logic              hit, ovf_evt, cmp_evt;

  assign mode_e = tm_mode_e'(mode);

  tmr_compare #(.BYTE_W(BYTE_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .we      (cmp_we),
    .wdata   (cmp_wdata),
    .lo_val  (lo_q),
    .top_val (top_val),
    .hit     (hit)
  );

  tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .mode    (mode_e),
    .lo_we   (cnt_lo_we),
    .hi_we   (cnt_hi_we),
    .wdata   (cnt_wdata),
    .hit     (hit),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .ovf_evt (ovf_evt),
    .cmp_evt (cmp_evt)
  );

  tmr_flag u_ovf (
    .clk     (clk),
    .rst     (rst),
    .set_evt (ovf_evt),
    .ack     (ovf_ack),
    .flag    (ovf_flag)
  );

  tmr_flag u_cmpf (
    .clk     (clk),
    .rst     (rst),
    .set_evt (cmp_evt),
    .ack     (cmp_ack),
    .flag    (cmp_flag)
  );

  assign count = {hi_q, lo_q};

  // R5: a tick on the top value clears the low byte in clear-on-compare mode
  p_ctc_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_lo_we && !cnt_hi_we && mode_e == TM_CLRCMP && lo_q == top_val)
      |=> (lo_q == '0));

  // R3: free 8-bit wrap leaves the high byte alone
  p_free8_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_lo_we && !cnt_hi_we && mode_e == TM_FREE8 && (&lo_q))
      |=> (lo_q == '0 && $stable(hi_q)));

  // R4: the overflow flag rises exactly as the wide count returns to zero
  p_wide_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_lo_we && !cnt_hi_we && mode_e == TM_FREE16 && (&count))
      |=> (count == '0 && ovf_flag));

endmodule

// File: tb/mtc_timer_bench.sv
`timescale 1ns/1ps
module mtc_timer_bench;

  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          cnt_lo_we = 1'b0, cnt_hi_we = 1'b0, cmp_we = 1'b0;
  logic [BW-1:0] cnt_wdata = '0, cmp_wdata = '0;
  logic          ovf_ack = 1'b0, cmp_ack = 1'b0;
  logic          ovf_flag, cmp_flag;
  logic [2*BW-1:0] count;

  always #4 clk = ~clk;

  mtc_timer #(.BYTE_W(BW)) u_mtc_timer (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode),
    .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .count(count)
  );

  typedef struct {
    int            due;
    logic [2*BW-1:0] cnt;
    logic          ovf;
    logic          cf;
    string         req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 1'b0;

  // reference model state
  logic [BW-1:0] m_lo = '0, m_hi = '0, m_cmp = '0;
  logic          m_ovf = 1'b0, m_cf = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic [2*BW-1:0] ac, input logic ao, input logic af,
                       input exp_t e);
    compared++;
    if (ac !== e.cnt || ao !== e.ovf || af !== e.cf) begin
      mismatched++;
      $display("FAIL %s: count=%h ovf=%b cmp=%b, expected count=%h ovf=%b cmp=%b",
               e.req, ac, ao, af, e.cnt, e.ovf, e.cf);
    end
  endtask

  // monitor: pop each expected item in the cycle it is due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check(count, ovf_flag, cmp_flag, e);
    end
  end

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drv(input bit t, input bit lw, input bit hw, input logic [BW-1:0] wd,
                     input bit cw, input logic [BW-1:0] cd,
                     input bit oa, input bit ca, input string req);
    bit ev_o, ev_c;
    exp_t e;
    @(negedge clk);
    tick = t; cnt_lo_we = lw; cnt_hi_we = hw; cnt_wdata = wd;
    cmp_we = cw; cmp_wdata = cd; ovf_ack = oa; cmp_ack = ca;
    ev_o = 1'b0; ev_c = 1'b0;
    if (lw || hw) begin
      if (lw) m_lo = wd;
      if (hw) m_hi = wd;
    end else if (t) begin
      ev_c = (m_lo == m_cmp);
      case (mode)
        2'd1: begin ev_o = (m_lo == 8'hFF); m_lo = ev_c ? 8'h00 : m_lo + 8'd1; end
        2'd2: begin ev_o = ({m_hi, m_lo} == 16'hFFFF); {m_hi, m_lo} = {m_hi, m_lo} + 16'd1; end
        default: begin ev_o = (m_lo == 8'hFF); m_lo = m_lo + 8'd1; end
      endcase
    end
    if (cw) m_cmp = cd;
    m_ovf = ev_o | (m_ovf & ~oa);
    m_cf  = ev_c | (m_cf & ~ca);
    e.due = cyc + 1; e.cnt = {m_hi, m_lo}; e.ovf = m_ovf; e.cf = m_cf; e.req = req;
    q.push_back(e);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) drv(1, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic idles(input int n, input string req);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic wr_lo(input logic [BW-1:0] v, input string req);
    drv(0, 1, 0, v, 0, 0, 0, 0, req);
  endtask
  task automatic wr_hi(input logic [BW-1:0] v, input string req);
    drv(0, 0, 1, v, 0, 0, 0, 0, req);
  endtask
  task automatic wr_cmp(input logic [BW-1:0] v, input string req);
    drv(0, 0, 0, 0, 1, v, 0, 0, req);
  endtask
  task automatic ack_all(input string req);
    drv(0, 0, 0, 0, 0, 0, 1, 1, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #400000;
    compared++; mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values observed while reset is still high
    e0.due = 0; e0.cnt = '0; e0.ovf = 0; e0.cf = 0; e0.req = "R1";
    check(count, ovf_flag, cmp_flag, e0);
    rst = 1'b0;
    @(negedge clk);
    check(count, ovf_flag, cmp_flag, e0);  // R1 first cycle after reset

    // R2: no ticks, nothing moves
    mode = 2'd0;
    idles(3, "R2");
    // R1/R6: compare resets to zero, so the first tick at zero matches
    ticks(1, "R6");
    ack_all("R10");
    // R2: gapped ticks
    for (int i = 0; i < 4; i++) begin ticks(1, "R2"); idles(2, "R2"); end

    // R3/R11/R4: free 8-bit wrap with the high byte held
    wr_hi(8'h12, "R11");
    wr_lo(8'hFC, "R11");
    ticks(6, "R3");
    idles(2, "R4");
    ack_all("R10");
    idles(1, "R10");

    // R10: overflow event and acknowledge on the same edge
    wr_lo(8'hFF, "R11");
    drv(1, 0, 0, 0, 0, 0, 1, 0, "R10");
    idles(2, "R10");
    drv(0, 0, 0, 0, 0, 0, 1, 0, "R10");
    idles(1, "R10");

    // R9: write racing a tick
    drv(1, 1, 0, 8'hFF, 0, 0, 0, 0, "R9");
    drv(1, 0, 1, 8'h34, 0, 0, 0, 0, "R9");
    ticks(1, "R4");
    ack_all("R10");

    // R5/R6: clear-on-compare with top = 3
    mode = 2'd1;
    wr_hi(8'h00, "R11");
    wr_lo(8'h00, "R5");
    wr_cmp(8'h03, "R7");
    ack_all("R10");
    ticks(10, "R5");
    drv(1, 0, 0, 0, 0, 0, 0, 1, "R10");
    ticks(4, "R6");

    // R7: top lowered below the running count
    ack_all("R10");
    wr_cmp(8'h40, "R7");
    wr_lo(8'h30, "R7");
    ticks(3, "R7");
    wr_cmp(8'h10, "R7");
    ack_all("R10");
    ticks(240, "R7");

    // R8/R4/R6: wide mode carry, match without clear, wrap to zero
    mode = 2'd2;
    ack_all("R10");
    wr_cmp(8'h00, "R7");
    wr_hi(8'h00, "R11");
    wr_lo(8'hFE, "R11");
    ticks(4, "R8");
    ack_all("R10");
    wr_hi(8'hFF, "R11");
    wr_lo(8'hFD, "R11");
    ticks(5, "R8");
    idles(3, "R4");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule